// File: doc/BRIEF.md
# Palette Reload Sequencer

The sequencer refills a display palette from a table in system memory. Software programs a 1 KB-aligned table base and then sets a request bit. The block waits for vertical blanking, reads the palette area of the table, and writes each entry into the palette. The palette is either a 256-entry colour palette with 6-bit red, green and blue channels, or a 16-entry monochrome palette of 4-bit levels. The request bit reads back as 1 for the whole reload, and hardware clears it when the reload ends.

A companion control-table reload shares the same control register. When both are requested, the control-table reload runs first. It is modelled as a start/done handshake with an external agent. The memory side is a single-outstanding read master. It holds a request with an address and a size until a data-valid pulse returns the data.

Top module: `lut_reload_engine`

## Requirements
- R1: After reset both registers read 0, and `mem_req_o`, `pal_we_o`, `mono_we_o`, `ctl_start_o` and `done_o` are low.
- R2: The base register (`reg_sel_i`=1) stores bits 31:10 of the written value. Bits 9:0 always read as 0.
- R3: In colour mode the block issues 256 halfword reads (`mem_word_o`=0). Read n is at base + 0x100 + 2n, in ascending order, and takes its data from `mem_rdata_i[15:0]`. Entry n is written to `pal_idx_o`=n.
- R4: A colour halfword h is written as red = {h[15:11],0}, green = h[10:5] and blue = {h[4:0],0}.
- R5: In monochrome mode the block issues two word reads (`mem_word_o`=1), at base + 0x100 and then base + 0x104. Nibble k (bits 4k+3:4k) of word w becomes entry 8w+k. Entries are written one per cycle in ascending order.
- R6: In the control register (`reg_sel_i`=0), bit 0 requests the control-table reload and bit 1 requests the palette reload. Writing 1 sets the bit. The bit reads 1 until its reload finishes and then clears by itself. `ctl_start_o` stays high until `ctl_done_i` is seen.
- R7: When both bits are set in one write, `ctl_start_o` is raised first. No memory read is issued until the control-table reload has finished.
- R8: No memory read is issued before `vblank_i` has been seen high. If `vblank_i` falls during a reload, the reload still completes.
- R9: While `mem_req_o` is high and `mem_valid_i` is low, the request and address stay unchanged. The address advances only after a valid pulse.
- R10: In colour mode with `pal_ram_sel_i` low, a palette request issues no reads and no palette writes, and its bit clears.
- R11: Writing 1 to a bit that is already set has no effect. The reload is not restarted and produces no extra entries or completion pulses.
- R12: `done_o` pulses for exactly one cycle. That cycle is the first one in which the palette bit reads 0 after a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 base |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| color_mode_i | input | 1 | 1 colour palette, 0 monochrome palette |
| pal_ram_sel_i | input | 1 | Colour palette RAM selected as reload target |
| vblank_i | input | 1 | Vertical blanking active |
| ctl_start_o | output | 1 | Control-table reload running |
| ctl_done_i | input | 1 | Control-table reload finished |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_word_o | output | 1 | Read size: 1 word, 0 halfword |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| pal_we_o | output | 1 | Colour palette write |
| pal_idx_o | output | 8 | Colour palette entry |
| pal_r_o | output | 6 | Red value |
| pal_g_o | output | 6 | Green value |
| pal_b_o | output | 6 | Blue value |
| mono_we_o | output | 1 | Monochrome palette write |
| mono_idx_o | output | 4 | Monochrome palette entry |
| mono_val_o | output | 4 | Monochrome level |
| done_o | output | 1 | Palette reload completion pulse |

## Verification
An entry index that has slipped shows up at once as a wrong address on the next read request. It also puts an entry number or channel value out of step on the next palette write, one cycle after the data-valid pulse. A sequencer stuck in the wrong state shows as a request issued too early, or as no completion pulse. A request made too early is visible before blanking or while the control-table handshake is still open. A missing completion pulse leaves the request bit set, and is caught when the bench's bounded wait ends. A busy flag that clears or restarts at the wrong time changes the number of writes and completion pulses counted over one reload.

// File: rtl/lut_reload_pkg.sv
`timescale 1ns/1ps
package lut_reload_pkg;
  localparam int CH_W = 6;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CTL,
    S_WAIT_VB,
    S_FETCH,
    S_MONO
  } seq_state_e;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/lut_reload_regs.sv
`timescale 1ns/1ps
module lut_reload_regs #(
  parameter int ADDR_W   = 32,
  parameter int BASE_LSB = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic                       sel_i,
  input  logic [31:0]                wdata_i,
  input  logic                       ctl_clr_i,
  input  logic                       pal_clr_i,
  output logic [31:0]                rdata_o,
  output logic                       ctl_busy_o,
  output logic                       pal_busy_o,
  output logic [ADDR_W-1:BASE_LSB]   base_o,
  output logic                       done_o
);
  logic [ADDR_W-1:BASE_LSB] base_q;
  logic ctl_busy_q, pal_busy_q, done_q;
  logic wr_ctl, wr_base;
  logic unused_wbits;

  assign wr_ctl  = wr_en_i && !sel_i;
  assign wr_base = wr_en_i && sel_i;
  assign unused_wbits = ^wdata_i[BASE_LSB-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q     <= '0;
      ctl_busy_q <= 1'b0;
      pal_busy_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      if (wr_base) base_q <= wdata_i[ADDR_W-1:BASE_LSB];
      // clear wins; a set while busy is dropped
      if (ctl_clr_i)                   ctl_busy_q <= 1'b0;
      else if (wr_ctl && wdata_i[0])   ctl_busy_q <= 1'b1;
      if (pal_clr_i)                   pal_busy_q <= 1'b0;
      else if (wr_ctl && wdata_i[1])   pal_busy_q <= 1'b1;
      done_q <= pal_clr_i;
    end
  end

  always_comb begin
    if (sel_i) rdata_o = {base_q, {BASE_LSB{1'b0}}};
    else       rdata_o = {30'd0, pal_busy_q, ctl_busy_q};
  end

  assign ctl_busy_o = ctl_busy_q;
  assign pal_busy_o = pal_busy_q;
  assign base_o     = base_q;
  assign done_o     = done_q;

  a_r6_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_busy_q && !pal_clr_i |=> pal_busy_q);
  a_r12_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pal_busy_q) |-> done_q);
  a_r12_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !pal_busy_q);
endmodule

// File: rtl/lut_reload_unpack.sv
`timescale 1ns/1ps
module lut_reload_unpack
  import lut_reload_pkg::*;
(
  input  logic [15:0] hw_i,
  output rgb_t        rgb_o
);
  // 5-bit red/blue land in the upper bits, LSB forced low
  always_comb begin
    rgb_o.r = {hw_i[15:11], {(CH_W-5){1'b0}}};
    rgb_o.g = hw_i[10:5];
    rgb_o.b = {hw_i[4:0], {(CH_W-5){1'b0}}};
  end
endmodule

// File: rtl/lut_reload_seq.sv
`timescale 1ns/1ps
module lut_reload_seq
  import lut_reload_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BASE_LSB   = 10,
  parameter int PAL_DEPTH  = 256,
  parameter int MONO_DEPTH = 16,
  parameter int MONO_W     = 4,
  parameter int TBL_OFS    = 'h100
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         color_i,
  input  logic                         pal_sel_i,
  input  logic                         vblank_i,
  input  logic                         ctl_busy_i,
  input  logic                         pal_busy_i,
  input  logic [ADDR_W-1:BASE_LSB]     base_i,
  input  logic                         ctl_done_i,
  input  logic                         mem_valid_i,
  input  logic [31:0]                  mem_rdata_i,
  input  rgb_t                         rgb_i,
  output logic                         ctl_start_o,
  output logic                         ctl_clr_o,
  output logic                         pal_clr_o,
  output logic                         mem_req_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  output logic                         mem_word_o,
  output logic                         pal_we_o,
  output logic [$clog2(PAL_DEPTH)-1:0] pal_idx_o,
  output rgb_t                         pal_rgb_o,
  output logic                         mono_we_o,
  output logic [$clog2(MONO_DEPTH)-1:0] mono_idx_o,
  output logic [MONO_W-1:0]            mono_val_o
);
  localparam int PAL_IW   = $clog2(PAL_DEPTH);
  localparam int NIB_PW   = 32 / MONO_W;
  localparam int NIB_W    = $clog2(NIB_PW);
  localparam int NWORDS   = MONO_DEPTH / NIB_PW;
  localparam int WRD_W    = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(TBL_OFS);
  localparam logic [PAL_IW-1:0] PAL_LAST  = PAL_IW'(PAL_DEPTH - 1);
  localparam logic [PAL_IW-1:0] WORD_LAST = PAL_IW'(NWORDS - 1);
  localparam logic [NIB_W-1:0]  NIB_LAST  = NIB_W'(NIB_PW - 1);

  seq_state_e               state_q;
  logic [PAL_IW-1:0]        idx_q;
  logic [NIB_W-1:0]         nib_q;
  logic [31:0]              word_q;
  logic [ADDR_W-1:BASE_LSB] base_q;
  logic                     mode_q;
  logic                     pal_we_q;
  logic [PAL_IW-1:0]        pal_idx_q;
  rgb_t                     pal_rgb_q;
  logic skip, last_colour, last_mono, word_last;

  assign skip        = (state_q == S_IDLE) && !ctl_busy_i && pal_busy_i && color_i && !pal_sel_i;
  assign last_colour = (state_q == S_FETCH) && mode_q && mem_valid_i && (idx_q == PAL_LAST);
  assign word_last   = (idx_q == WORD_LAST);
  assign last_mono   = (state_q == S_MONO) && (nib_q == NIB_LAST) && word_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      nib_q     <= '0;
      word_q    <= '0;
      base_q    <= '0;
      mode_q    <= 1'b0;
      pal_we_q  <= 1'b0;
      pal_idx_q <= '0;
      pal_rgb_q <= '0;
    end else begin
      pal_we_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (ctl_busy_i) state_q <= S_CTL;
          else if (pal_busy_i && !skip) begin
            state_q <= S_WAIT_VB;
            mode_q  <= color_i;
            base_q  <= base_i;
            idx_q   <= '0;
            nib_q   <= '0;
          end
        end
        S_CTL:     if (ctl_done_i) state_q <= S_IDLE;
        S_WAIT_VB: if (vblank_i)   state_q <= S_FETCH;
        S_FETCH: begin
          if (mem_valid_i) begin
            if (mode_q) begin
              pal_we_q  <= 1'b1;
              pal_idx_q <= idx_q;
              pal_rgb_q <= rgb_i;
              idx_q     <= idx_q + 1'b1;
              if (last_colour) state_q <= S_IDLE;
            end else begin
              word_q  <= mem_rdata_i;
              nib_q   <= '0;
              state_q <= S_MONO;
            end
          end
        end
        S_MONO: begin
          nib_q <= nib_q + 1'b1;
          if (nib_q == NIB_LAST) begin
            if (word_last) state_q <= S_IDLE;
            else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= S_FETCH;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ctl_start_o = (state_q == S_CTL);
  assign ctl_clr_o   = (state_q == S_CTL) && ctl_done_i;
  assign pal_clr_o   = skip || last_colour || last_mono;
  assign mem_req_o   = (state_q == S_FETCH);
  assign mem_word_o  = !mode_q;
  assign mem_addr_o  = {base_q, {BASE_LSB{1'b0}}} + OFS +
                       (mode_q ? (ADDR_W'(idx_q) << 1) : (ADDR_W'(idx_q) << 2));
  assign pal_we_o    = pal_we_q;
  assign pal_idx_o   = pal_idx_q;
  assign pal_rgb_o   = pal_rgb_q;
  assign mono_we_o   = (state_q == S_MONO);
  assign mono_idx_o  = {idx_q[WRD_W-1:0], nib_q};
  assign mono_val_o  = word_q[int'(nib_q)*MONO_W +: MONO_W];

  a_r9_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));
  a_r8_wait_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT_VB) && !vblank_i |=> !mem_req_o);
  a_r7_ctl_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) && ctl_busy_i && pal_busy_i |=> ctl_start_o && !mem_req_o);
  a_r10_skip_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip |=> !mem_req_o && !pal_we_o);
endmodule

// File: rtl/lut_reload_engine.sv
`timescale 1ns/1ps
module lut_reload_engine
  import lut_reload_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BASE_LSB   = 10,
  parameter int PAL_DEPTH  = 256,
  parameter int MONO_DEPTH = 16,
  parameter int MONO_W     = 4,
  parameter int TBL_OFS    = 'h100,
  localparam int PAL_IW    = $clog2(PAL_DEPTH),
  localparam int MONO_IW   = $clog2(MONO_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               color_mode_i,
  input  logic               pal_ram_sel_i,
  input  logic               vblank_i,
  output logic               ctl_start_o,
  input  logic               ctl_done_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_word_o,
  input  logic               mem_valid_i,
  input  logic [31:0]        mem_rdata_i,
  output logic               pal_we_o,
  output logic [PAL_IW-1:0]  pal_idx_o,
  output logic [CH_W-1:0]    pal_r_o,
  output logic [CH_W-1:0]    pal_g_o,
  output logic [CH_W-1:0]    pal_b_o,
  output logic               mono_we_o,
  output logic [MONO_IW-1:0] mono_idx_o,
  output logic [MONO_W-1:0]  mono_val_o,
  output logic               done_o
);
  logic ctl_busy, pal_busy, ctl_clr, pal_clr;
  logic [ADDR_W-1:BASE_LSB] base;
  rgb_t rgb_unp, rgb_wr;

  lut_reload_regs #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(reg_wr_i), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .ctl_clr_i(ctl_clr), .pal_clr_i(pal_clr),
    .rdata_o(reg_rdata_o), .ctl_busy_o(ctl_busy), .pal_busy_o(pal_busy),
    .base_o(base), .done_o(done_o)
  );

  lut_reload_unpack u_unpack (.hw_i(mem_rdata_i[15:0]), .rgb_o(rgb_unp));

  lut_reload_seq #(
    .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .PAL_DEPTH(PAL_DEPTH),
    .MONO_DEPTH(MONO_DEPTH), .MONO_W(MONO_W), .TBL_OFS(TBL_OFS)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .color_i(color_mode_i), .pal_sel_i(pal_ram_sel_i),
    .vblank_i(vblank_i), .ctl_busy_i(ctl_busy), .pal_busy_i(pal_busy), .base_i(base),
    .ctl_done_i(ctl_done_i), .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i),
    .rgb_i(rgb_unp), .ctl_start_o(ctl_start_o), .ctl_clr_o(ctl_clr), .pal_clr_o(pal_clr),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_word_o(mem_word_o),
    .pal_we_o(pal_we_o), .pal_idx_o(pal_idx_o), .pal_rgb_o(rgb_wr),
    .mono_we_o(mono_we_o), .mono_idx_o(mono_idx_o), .mono_val_o(mono_val_o)
  );

  assign pal_r_o = rgb_wr.r;
  assign pal_g_o = rgb_wr.g;
  assign pal_b_o = rgb_wr.b;
endmodule

// File: tb/lut_reload_engine_test.sv
`timescale 1ns/1ps
module lut_reload_engine_test;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_wr_i = 1'b0, reg_sel_i = 1'b0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic color_mode_i = 1'b1, pal_ram_sel_i = 1'b1, vblank_i = 1'b0;
  logic ctl_start_o, ctl_done_i = 1'b0;
  logic mem_req_o, mem_word_o, mem_valid_i = 1'b0;
  logic [31:0] mem_addr_o, mem_rdata_i = '0;
  logic pal_we_o, mono_we_o, done_o;
  logic [7:0] pal_idx_o;
  logic [5:0] pal_r_o, pal_g_o, pal_b_o;
  logic [3:0] mono_idx_o, mono_val_o;

  lut_reload_engine uut (.*);

  always #10 clk_i = ~clk_i;

  int tests = 0, fails = 0;
  int lat = 0, nreq = 0, pal_cnt = 0, mono_cnt = 0, done_cnt = 0, ctl_runs = 0, ctl_cnt = 0, wcnt = 0;
  logic [31:0] exp_base = '0, hold_addr = '0;
  logic exp_color = 1'b1, vb_seen = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] hw_at(input logic [31:0] a);
    logic [31:0] t;
    t = (a * 32'h9E37) ^ (a >> 3) ^ 32'h5A5A;
    return t[15:0];
  endfunction

  // memory responder: single outstanding read, programmable latency
  always @(negedge clk_i) begin
    if (mem_valid_i) mem_valid_i = 1'b0;
    else if (mem_req_o) begin
      if (wcnt > 0) chk("R9 addr stable", mem_addr_o, hold_addr);
      hold_addr = mem_addr_o;
      if (wcnt >= lat) begin
        if (exp_color) begin
          chk("R3 addr", mem_addr_o, exp_base + 32'h100 + 32'(2 * nreq));
          chk("R3 size", {31'd0, mem_word_o}, 32'd0);
          mem_rdata_i = {16'hDEAD, hw_at(mem_addr_o)};
        end else begin
          chk("R5 addr", mem_addr_o, exp_base + 32'h100 + 32'(4 * nreq));
          chk("R5 size", {31'd0, mem_word_o}, 32'd1);
          mem_rdata_i = {hw_at(mem_addr_o + 2), hw_at(mem_addr_o)};
        end
        if (nreq == 0) chk("R8 read after blank", {31'd0, vb_seen}, 32'd1);
        chk("R7 no read during ctl", {31'd0, ctl_start_o}, 32'd0);
        nreq++;
        wcnt = 0;
        mem_valid_i = 1'b1;
      end else wcnt++;
    end
  end

  // control-table stub
  always @(negedge clk_i) begin
    if (ctl_done_i) begin
      ctl_done_i = 1'b0;
      ctl_cnt = 0;
      ctl_runs++;
    end else if (ctl_start_o) begin
      ctl_cnt++;
      if (ctl_cnt == 4) ctl_done_i = 1'b1;
    end
  end

  // palette write reference
  always @(negedge clk_i) begin
    if (pal_we_o) begin
      logic [15:0] h;
      h = hw_at(exp_base + 32'h100 + 32'(2 * pal_cnt));
      chk("R3 entry", {24'd0, pal_idx_o}, 32'(pal_cnt));
      chk("R4 red",   {26'd0, pal_r_o}, {26'd0, h[15:11], 1'b0});
      chk("R4 green", {26'd0, pal_g_o}, {26'd0, h[10:5]});
      chk("R4 blue",  {26'd0, pal_b_o}, {26'd0, h[4:0], 1'b0});
      pal_cnt++;
    end
    if (mono_we_o) begin
      logic [31:0] a, w;
      a = exp_base + 32'h100 + 32'(4 * (mono_cnt / 8));
      w = {hw_at(a + 2), hw_at(a)};
      chk("R5 entry", {28'd0, mono_idx_o}, 32'(mono_cnt));
      chk("R5 level", {28'd0, mono_val_o}, {28'd0, w[4*(mono_cnt%8) +: 4]});
      mono_cnt++;
    end
    if (done_o) begin
      done_cnt++;
      if (!reg_sel_i) chk("R12 bit clear at done", {31'd0, reg_rdata_o[1]}, 32'd0);
    end
  end

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_sel_i = 1'b0;
  endtask

  task automatic run(input logic color, input logic sel, input int latency,
                     input logic [31:0] base, input int vb_delay, input int vb_len,
                     input logic both, input logic rewrite);
    int exp_reads, exp_pal, exp_mono, cyc;
    color_mode_i = color; pal_ram_sel_i = sel; lat = latency;
    exp_color = color; exp_base = {base[31:10], 10'd0};
    nreq = 0; pal_cnt = 0; mono_cnt = 0; done_cnt = 0; ctl_runs = 0; wcnt = 0; vb_seen = 1'b0;
    exp_reads = !color ? 2 : (sel ? 256 : 0);
    exp_pal   = (color && sel) ? 256 : 0;
    exp_mono  = color ? 0 : 16;
    reg_write(1'b1, base);
    reg_write(1'b0, both ? 32'd3 : 32'd2);
    if (exp_reads != 0) chk("R6 busy reads 1", {31'd0, reg_rdata_o[1]}, 32'd1);
    if (both) chk("R6 ctl bit reads 1", {31'd0, reg_rdata_o[0]}, 32'd1);
    repeat (vb_delay) @(negedge clk_i);
    vblank_i = 1'b1; vb_seen = 1'b1;
    cyc = 0;
    while (done_cnt == 0 && cyc < 6000) begin
      @(negedge clk_i);
      cyc++;
      if (cyc == vb_len) vblank_i = 1'b0;
      if (rewrite && cyc == 40) begin
        reg_write(1'b0, 32'd2);
        cyc += 2;
      end
    end
    chk("R12 reload finished", {31'd0, done_cnt != 0}, 32'd1);
    repeat (20) @(negedge clk_i);
    vblank_i = 1'b0;
    chk(rewrite ? "R11 single completion" : "R12 single pulse", 32'(done_cnt), 32'd1);
    chk(color ? (sel ? "R3 read count" : "R10 no reads") : "R5 read count", 32'(nreq), 32'(exp_reads));
    chk(sel ? "R3 write count" : "R10 no writes", 32'(pal_cnt), 32'(exp_pal));
    chk("R5 mono count", 32'(mono_cnt), 32'(exp_mono));
    chk("R6 busy cleared", {30'd0, reg_rdata_o[1:0]}, 32'd0);
    chk("R7 ctl runs", 32'(ctl_runs), both ? 32'd1 : 32'd0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 ctl reg", reg_rdata_o, 32'd0);
    chk("R1 outputs", {27'd0, mem_req_o, pal_we_o, mono_we_o, ctl_start_o, done_o}, 32'd0);
    reg_sel_i = 1'b1; #1;
    chk("R1 base reg", reg_rdata_o, 32'd0);
    reg_sel_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2 base alignment
    reg_write(1'b1, 32'h1234_56FF);
    reg_sel_i = 1'b1; #1;
    chk("R2 base low bits", reg_rdata_o, 32'h1234_5400);
    reg_sel_i = 1'b0;
    // R3 R4 colour, zero latency
    run(1'b1, 1'b1, 0, 32'h0001_2C00, 3, 0, 1'b0, 1'b0);
    // R8 R9 colour, latency 3, blank drops mid-run
    run(1'b1, 1'b1, 3, 32'h8000_0400, 12, 30, 1'b0, 1'b0);
    // R5 monochrome
    run(1'b0, 1'b1, 2, 32'h0000_FC00, 2, 0, 1'b0, 1'b0);
    // R7 both requests in one write
    run(1'b1, 1'b1, 1, 32'h0040_0000, 1, 0, 1'b1, 1'b0);
    // R11 request rewritten while busy
    run(1'b1, 1'b1, 1, 32'h0300_0800, 1, 0, 1'b0, 1'b1);
    // R10 colour target not selected
    run(1'b1, 1'b0, 0, 32'h0000_0C00, 1, 0, 1'b0, 1'b0);
    finish_run();
  end
endmodule